// File: doc/BRIEF.md
# Tournament Hybrid Branch Direction Predictor

This block predicts the direction of a conditional branch by consulting two direction predictors at once for the same fetch address. The first keeps a table of 2-bit saturating counters selected by the low address bits alone. The second keeps a table of the same kind of counters, but selects its entry by the address bits XORed with a register of recent branch outcomes. A third table of 2-bit counters, selected by address, learns for each branch which of the two to trust, and the block's prediction is taken from that one.

The fetch side is purely combinational. It returns the final prediction, which component supplied it, both component predictions and the current outcome history. The fetch stage keeps these and hands them back on the resolve side together with the actual outcome. Every resolved branch trains both components. The chooser is trained only when the two components disagreed. The outcome history shifts in each resolved outcome.

Top module: `tourn_predictor`

## Requirements
- R1: While reset is held, and directly after it, every counter in the three tables is 01 (weakly not-taken, chooser weakly bimodal) and the history is zero. For any fetch address, predTaken, predUseGlobal, predBim and predGlb are all 0 and fetchHist is 0.
- R2: The address-indexed counter for entry fetchPc[IDX_W-1:0] saturates at 0 and 3. A taken resolve adds one and a not-taken resolve subtracts one. predBim is bit 1 of that counter.
- R3: The history component's entry is fetchPc[IDX_W-1:0] XOR the zero-extended history on fetch, and resPc[IDX_W-1:0] XOR resHist on resolve. predGlb is bit 1 of that counter, which saturates in the same way as in R2.
- R4: On each resolve the history becomes {old history[HIST_W-2:0], resTaken}, with the newest outcome in bit 0. fetchHist shows the current history.
- R5: When resBimPred differs from resGlbPred, the chooser entry at resPc[IDX_W-1:0] steps up if resGlbPred equals resTaken and steps down otherwise, saturating at 0 and 3. When they agree, the chooser is left unchanged.
- R6: predUseGlobal is bit 1 of the chooser entry at fetchPc[IDX_W-1:0], so a value of 2 or 3 selects the history component. predTaken equals predGlb when predUseGlobal is 1 and predBim otherwise.
- R7: Both component tables are trained on every resolve, whatever the chooser selected.
- R8: A fetch in the same cycle as a resolve, even to the same entry, sees the table and history values from before that resolve. The update is visible from the next cycle.
- R9: With resValid low, nothing changes, whatever the other resolve inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| fetchPc | input | PC_W | Fetch address of the branch being looked up |
| predTaken | output | 1 | Final direction prediction |
| predUseGlobal | output | 1 | 1 when the history component supplied predTaken |
| predBim | output | 1 | Address-indexed component's prediction |
| predGlb | output | 1 | History component's prediction |
| fetchHist | output | HIST_W | History snapshot at fetch time |
| resValid | input | 1 | A branch resolves this cycle |
| resPc | input | PC_W | Address of the resolving branch |
| resTaken | input | 1 | Actual outcome, 1 = taken |
| resBimPred | input | 1 | predBim recorded at fetch |
| resGlbPred | input | 1 | predGlb recorded at fetch |
| resHist | input | HIST_W | fetchHist recorded at fetch |

## Verification
Lookup and training can fall in the same cycle, including on the same table entry. The bench provokes this with directed cycles where fetchPc equals resPc, and throughout a long mixed sweep in which the fetch and resolve addresses are drawn independently. It judges the result against a reference model whose values are sampled before the clock edge and only then updated: a correct design shows the old counter in that cycle and the new one in the next. Full address sweeps with resolve idle then read every entry back through the fetch outputs.

// File: rtl/tourn_pkg.sv
package tourn_pkg;

  // Write strobes handed from control to datapath
  typedef struct packed {
    logic bimUpd;
    logic glbUpd;
    logic choUpd;
    logic choInc;
    logic histShift;
  } upd_t;

  localparam logic [1:0] CNT_RESET = 2'b01;

  function automatic logic [1:0] satStep(input logic [1:0] cnt, input logic up);
    logic [1:0] nxt;
    if (up) nxt = (cnt == 2'd3) ? cnt : cnt + 2'd1;
    else    nxt = (cnt == 2'd0) ? cnt : cnt - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/tourn_ctrl.sv
module tourn_ctrl (
  input  logic            clk,
  input  logic            rstN,
  input  logic            resValid,
  input  logic            resTaken,
  input  logic            resBimPred,
  input  logic            resGlbPred,
  output tourn_pkg::upd_t upd
);
  logic disagree;

  assign disagree = resBimPred ^ resGlbPred;

  always_comb begin
    upd           = '0;
    upd.bimUpd    = resValid;
    upd.glbUpd    = resValid;
    upd.histShift = resValid;
    upd.choUpd    = resValid & disagree;
    upd.choInc    = (resGlbPred == resTaken);
  end

  // R5: chooser left alone when the components agreed
  p_cho_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (resBimPred == resGlbPred) |-> !upd.choUpd);

  // R9: no write strobe without a resolve
  p_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> (upd.bimUpd == 1'b0 && upd.glbUpd == 1'b0 && upd.choUpd == 1'b0));

endmodule

// File: rtl/tourn_dp.sv
module tourn_dp #(
  parameter int PC_W   = 8,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  tourn_pkg::upd_t   upd,
  input  logic [PC_W-1:0]   fetchPc,
  input  logic [PC_W-1:0]   resPc,
  input  logic              resTaken,
  input  logic [HIST_W-1:0] resHist,
  output logic              predBim,
  output logic              predGlb,
  output logic              predUseGlobal,
  output logic              predTaken,
  output logic [HIST_W-1:0] fetchHist
);
  import tourn_pkg::*;

  localparam int DEPTH = 1 << IDX_W;

  logic [1:0]        bimTbl [DEPTH];
  logic [1:0]        glbTbl [DEPTH];
  logic [1:0]        choTbl [DEPTH];
  logic [HIST_W-1:0] hist;

  logic [IDX_W-1:0] fBIdx, fGIdx, rBIdx, rGIdx;

  assign fBIdx = fetchPc[IDX_W-1:0];
  assign fGIdx = fBIdx ^ IDX_W'(hist);
  assign rBIdx = resPc[IDX_W-1:0];
  assign rGIdx = rBIdx ^ IDX_W'(resHist);

  // Lookup reads the registered state, so a same-cycle write is seen next cycle
  assign predBim       = bimTbl[fBIdx][1];
  assign predGlb       = glbTbl[fGIdx][1];
  assign predUseGlobal = choTbl[fBIdx][1];
  assign predTaken     = predUseGlobal ? predGlb : predBim;
  assign fetchHist     = hist;

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk) begin
        if (!rstN) begin
          bimTbl[e] <= CNT_RESET;
          glbTbl[e] <= CNT_RESET;
          choTbl[e] <= CNT_RESET;
        end else begin
          if (upd.bimUpd && rBIdx == IDX_W'(e))
            bimTbl[e] <= satStep(bimTbl[e], resTaken);
          if (upd.glbUpd && rGIdx == IDX_W'(e))
            glbTbl[e] <= satStep(glbTbl[e], resTaken);
          if (upd.choUpd && rBIdx == IDX_W'(e))
            choTbl[e] <= satStep(choTbl[e], upd.choInc);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)              hist <= '0;
    else if (upd.histShift) hist <= {hist[HIST_W-2:0], resTaken};
  end

  // R4: newest outcome lands in bit 0
  p_hist_in_r4: assert property (@(posedge clk) disable iff (!rstN)
    upd.histShift |=> hist[0] == $past(resTaken));

  // R2: a saturated taken counter stays at 3
  p_bim_sat_r2: assert property (@(posedge clk) disable iff (!rstN)
    (upd.bimUpd && resTaken && bimTbl[rBIdx] == 2'd3) |=> bimTbl[$past(rBIdx)] == 2'd3);

  // R7: the history component trains on a taken resolve below saturation
  p_glb_inc_r7: assert property (@(posedge clk) disable iff (!rstN)
    (upd.glbUpd && resTaken && glbTbl[rGIdx] != 2'd3)
      |=> glbTbl[$past(rGIdx)] == $past(glbTbl[rGIdx]) + 2'd1);

  // R9: history holds while nothing resolves
  p_hist_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !upd.histShift |=> $stable(hist));

endmodule

// File: rtl/tourn_predictor.sv
module tourn_predictor #(
  parameter int PC_W   = 8,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   fetchPc,
  output logic              predTaken,
  output logic              predUseGlobal,
  output logic              predBim,
  output logic              predGlb,
  output logic [HIST_W-1:0] fetchHist,
  input  logic              resValid,
  input  logic [PC_W-1:0]   resPc,
  input  logic              resTaken,
  input  logic              resBimPred,
  input  logic              resGlbPred,
  input  logic [HIST_W-1:0] resHist
);
  tourn_pkg::upd_t upd;

  tourn_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .resValid   (resValid),
    .resTaken   (resTaken),
    .resBimPred (resBimPred),
    .resGlbPred (resGlbPred),
    .upd        (upd)
  );

  tourn_dp #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .upd           (upd),
    .fetchPc       (fetchPc),
    .resPc         (resPc),
    .resTaken      (resTaken),
    .resHist       (resHist),
    .predBim       (predBim),
    .predGlb       (predGlb),
    .predUseGlobal (predUseGlobal),
    .predTaken     (predTaken),
    .fetchHist     (fetchHist)
  );

endmodule

// File: tb/tb_tourn_predictor.sv
`timescale 1ns/1ps
module tb_tourn_predictor;
  localparam int PC_W   = 8;
  localparam int IDX_W  = 4;
  localparam int HIST_W = 4;
  localparam int DEPTH  = 1 << IDX_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PC_W-1:0] fetchPc = '0;
  logic predTaken, predUseGlobal, predBim, predGlb;
  logic [HIST_W-1:0] fetchHist;
  logic resValid = 1'b0;
  logic [PC_W-1:0] resPc = '0;
  logic resTaken = 1'b0, resBimPred = 1'b0, resGlbPred = 1'b0;
  logic [HIST_W-1:0] resHist = '0;

  always #4 clk = ~clk;

  tourn_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) dut (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc),
    .predTaken(predTaken), .predUseGlobal(predUseGlobal),
    .predBim(predBim), .predGlb(predGlb), .fetchHist(fetchHist),
    .resValid(resValid), .resPc(resPc), .resTaken(resTaken),
    .resBimPred(resBimPred), .resGlbPred(resGlbPred), .resHist(resHist)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state
  logic [1:0] mBim [DEPTH];
  logic [1:0] mGlb [DEPTH];
  logic [1:0] mCho [DEPTH];
  logic [HIST_W-1:0] mHist;

  function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < DEPTH; i++) begin
      mBim[i] = 2'b01; mGlb[i] = 2'b01; mCho[i] = 2'b01;
    end
    mHist = '0;
  endtask

  task automatic cmp(input string ph, input string rq, input string what,
                     input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s %s pc=%0d got %0b expected %0b", ph, rq, what, fetchPc, got, exp);
    end
  endtask

  task automatic checkFetch(input string ph);
    logic [IDX_W-1:0] bi, gi;
    logic eB, eG, eU;
    bi = fetchPc[IDX_W-1:0];
    gi = bi ^ IDX_W'(mHist);
    eB = mBim[bi][1]; eG = mGlb[gi][1]; eU = mCho[bi][1];
    cmp(ph, "R2", "predBim", predBim, eB);
    cmp(ph, "R3", "predGlb", predGlb, eG);
    cmp(ph, "R5", "predUseGlobal", predUseGlobal, eU);
    cmp(ph, "R6", "predTaken", predTaken, eU ? eG : eB);
    checks++;
    if (fetchHist !== mHist) begin
      errors++;
      $display("FAIL %s R4 fetchHist got %0h expected %0h", ph, fetchHist, mHist);
    end
  endtask

  // One cycle: drive at negedge, check before the edge, update model after it
  task automatic step(input logic [PC_W-1:0] fpc, input logic v, input logic [PC_W-1:0] rpc,
                      input logic rt, input logic [HIST_W-1:0] rh, input string ph);
    logic [IDX_W-1:0] bi, gi;
    @(negedge clk);
    bi = rpc[IDX_W-1:0];
    gi = bi ^ IDX_W'(rh);
    fetchPc = fpc; resValid = v; resPc = rpc; resTaken = rt; resHist = rh;
    resBimPred = mBim[bi][1];
    resGlbPred = mGlb[gi][1];
    #1 checkFetch(ph);
    @(posedge clk);
    if (v) begin
      if (resBimPred != resGlbPred) mCho[bi] = sat(mCho[bi], resGlbPred == rt);
      mBim[bi] = sat(mBim[bi], rt);
      mGlb[gi] = sat(mGlb[gi], rt);
      mHist = {mHist[HIST_W-2:0], rt};
    end
  endtask

  task automatic sweep(input string ph);
    for (int p = 0; p < DEPTH; p++) step(PC_W'(p), 1'b0, '0, 1'b0, '0, ph);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    modelReset();
    // R1: state during and right after reset
    repeat (3) @(posedge clk);
    for (int p = 0; p < DEPTH; p++) begin
      @(negedge clk); fetchPc = PC_W'(p);
      #1 checkFetch("R1 in reset");
    end
    @(negedge clk); rstN = 1'b1;
    sweep("R1 after reset");

    // R2: saturation and hysteresis on one entry
    for (int k = 0; k < 4; k++) step(8'h05, 1'b1, 8'h05, 1'b1, mHist, "R2 up");
    step(8'h05, 1'b1, 8'h05, 1'b0, mHist, "R2 down");
    step(8'h05, 1'b0, '0, 1'b0, '0, "R2 hold");
    for (int k = 0; k < 5; k++) step(8'h05, 1'b1, 8'h05, 1'b0, mHist, "R2 floor");

    // R5/R6/R7: train chooser toward history component on entry 9, alternating pattern
    for (int k = 0; k < 40; k++) step(8'h09, 1'b1, 8'h09, k[0], mHist, "R5 train");
    sweep("R7 readback");

    // R8: fetch and resolve the same entry in the same cycle
    for (int k = 0; k < 12; k++) step(8'h0c, 1'b1, 8'h0c, 1'b1, mHist, "R8 same");
    for (int k = 0; k < 6; k++) step(8'h0c, 1'b1, 8'h0c, 1'b0, mHist, "R8 same");

    // Mixed sweep: independent fetch/resolve addresses, mostly live history
    for (int k = 0; k < 4000; k++) begin
      logic [HIST_W-1:0] h;
      h = ($urandom_range(0, 9) < 7) ? mHist : HIST_W'($urandom);
      step(PC_W'($urandom), ($urandom_range(0, 3) != 0), PC_W'($urandom),
           ($urandom_range(0, 4) != 0), h, "mix R3 R8");
    end
    sweep("mix readback");

    // R9: garbage on resolve inputs with resValid low
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      resValid = 1'b0; resPc = PC_W'($urandom); resTaken = 1'($urandom);
      resBimPred = 1'($urandom); resGlbPred = 1'($urandom); resHist = HIST_W'($urandom);
      fetchPc = PC_W'($urandom);
      #1 checkFetch("R9 idle");
    end
    sweep("R9 readback");

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule